// File: doc/BRIEF.md
# Serial Half-Precision Floating-Point Adder

This block adds two half-precision floating-point numbers that arrive one bit per clock. Each operand uses two wires. One wire carries its 11-bit significand, with the leading one written out. The other wire carries a 6-bit word that holds a biased 5-bit exponent and a sign. Both wires of both operands are sent side by side. A one-cycle start strobe marks bit 0 of every operand pair. The sum leaves on the same pair of wires in the same format, and an output-valid strobe marks its bit 0.

Inside the block, the collected operands pass through three fixed steps. First, the operand with the smaller magnitude is shifted right to the larger exponent and rounded while it is shifted. Second, the significands are added or subtracted. Third, the result is normalized and its exponent is corrected. A new operand pair can start every 12 cycles. NaN, infinity, denormal inputs and exception flags are not handled. Exponent overflow wraps modulo 32.

Top module: `fsa_serial_add`

## Requirements
- R1: Serial framing. A significand is 11 bits, sent LSB first. The sign/exponent word is 6 bits, sent LSB first: bits 0 to 4 are the exponent and bit 5 is the sign. The start strobe is high in the same cycle as bit 0 of both operands.
- R2: The output-valid strobe is high for exactly one cycle, 14 clock cycles after the cycle in which the start strobe was sampled. Result bit 0 is on the output wires in that cycle, and the following bits come in the next cycles in the format of R1.
- R3: Operand pairs whose start strobes are 12 cycles apart each give a correct result, and the results leave 12 cycles apart.
- R4: The operand with the larger exponent keeps its significand. The other operand is shifted right by the exponent difference. When the exponents are equal, the operand with the larger or equal significand is the minuend.
- R5: The shifted significand is rounded to nearest, ties to even. The first bit shifted out is the guard bit, and the OR of all bits after it is the sticky bit. The value is rounded up when guard=1 and either sticky=1 or the kept LSB=1.
- R6: When the signs differ, the significands are subtracted, larger minus smaller. The result takes the sign of the larger-magnitude operand.
- R7: A carry out of the significand sum shifts the result right by one, dropping its LSB, and raises the exponent by one.
- R8: A sum with leading zeros is shifted left until bit 10 is set, and the exponent is lowered by the shift count.
- R9: A zero sum gives significand 0, exponent 0 and sign 0.
- R10: When the left-shift count is greater than or equal to the larger exponent, the result is flushed to zero in the form of R9.
- R11: After reset, the output-valid strobe is low and both output wires are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_start | input | 1 | Marks bit 0 of a new operand pair |
| a_sig | input | 1 | Operand A significand, serial |
| a_se | input | 1 | Operand A sign/exponent, serial |
| b_sig | input | 1 | Operand B significand, serial |
| b_se | input | 1 | Operand B sign/exponent, serial |
| out_sig | output | 1 | Result significand, serial |
| out_se | output | 1 | Result sign/exponent, serial |
| out_valid | output | 1 | Marks bit 0 of a result |

## Verification
The bench targets the rounding ties:
- A tie with an even kept part must stay put, and a tie with an odd kept part must round up. A design without the ties-to-even rule would differ by one LSB.
- A shift of exactly 11 leaves only guard and sticky bits, and a truncating design would lose the rounded-up one.

Several cases exercise normalization:
- An equal-exponent subtraction in which B is larger must give B's sign. A design that always subtracts B from A would produce a negative magnitude.
- Cancellations must give a large left shift, an exact zero with a positive sign, and an underflow flush. A design without the flush would wrap the exponent.
- A carry case checks the right shift and the exponent step.

Back-to-back frames catch a design that reuses input or output registers too early. The checked output latency catches any extra or missing pipeline stage.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
  parameter int MW  = 11;          // significand width incl. leading one
  parameter int EW  = 5;           // exponent width
  localparam int SEW = EW + 1;     // sign/exponent stream width
  localparam int SHW = 2 ** EW;    // widest possible alignment shift

  typedef struct packed {
    logic          sgn;
    logic [EW-1:0] exp;
    logic [MW-1:0] sig;
  } fsa_word_t;

  // right shift by d with nearest-even rounding from guard/sticky
  function automatic logic [MW:0] align_rnd(input logic [MW-1:0] m, input logic [EW-1:0] d);
    logic [MW+SHW-1:0] ext;
    logic [MW-1:0]     kept;
    logic              g, s;
    ext  = {m, {SHW{1'b0}}} >> d;
    kept = ext[MW+SHW-1:SHW];
    g    = ext[SHW-1];
    s    = |ext[SHW-2:0];
    return {1'b0, kept} + (MW+1)'(g & (s | kept[0]));
  endfunction

  function automatic logic [EW-1:0] lead_zeros(input logic [MW-1:0] v);
    logic [EW-1:0] n;
    logic          hit;
    n   = '0;
    hit = 1'b0;
    for (int i = MW - 1; i >= 0; i--) begin
      if (!hit && !v[i]) n = n + 1'b1;
      if (v[i]) hit = 1'b1;
    end
    return n;
  endfunction

  function automatic fsa_word_t normalize(input logic [MW:0] sum, input logic [EW-1:0] e,
                                          input logic sgn);
    fsa_word_t     w;
    logic [EW-1:0] lz;
    logic [MW-1:0] sh;
    lz = lead_zeros(sum[MW-1:0]);
    sh = sum[MW-1:0] << lz;
    if (sum[MW]) begin
      w = '{sgn: sgn, exp: e + 1'b1, sig: sum[MW:1]};
    end else if (sum == '0 || lz >= e) begin
      w = '0;
    end else begin
      w = '{sgn: sgn, exp: e - lz, sig: sh};
    end
    return w;
  endfunction
endpackage

// File: rtl/fsa_rx.sv
module fsa_rx #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (shift) q <= {din, q[W-1:1]};
  end
endmodule

// File: rtl/fsa_core.sv
module fsa_core
  import fsa_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld,
  input  logic [MW-1:0]   a_sig,
  input  logic [SEW-1:0]  a_se,
  input  logic [MW-1:0]   b_sig,
  input  logic [SEW-1:0]  b_se,
  output logic            res_v,
  output fsa_word_t       res
);
  logic [EW-1:0] ea, eb;
  logic          a_first;
  assign ea = a_se[EW-1:0];
  assign eb = b_se[EW-1:0];
  assign a_first = (ea > eb) || (ea == eb && a_sig >= b_sig);

  // stage A: order and align
  logic          al_v, al_sub, al_sgn;
  logic [EW-1:0] al_exp;
  logic [MW:0]   al_big, al_small;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_v <= 1'b0; al_sub <= 1'b0; al_sgn <= 1'b0;
      al_exp <= '0; al_big <= '0; al_small <= '0;
    end else begin
      al_v <= ld;
      if (ld) begin
        al_sub <= a_se[EW] ^ b_se[EW];
        al_sgn <= a_first ? a_se[EW] : b_se[EW];
        al_exp <= a_first ? ea : eb;
        al_big <= {1'b0, a_first ? a_sig : b_sig};
        al_small <= a_first ? align_rnd(b_sig, ea - eb) : align_rnd(a_sig, eb - ea);
      end
    end
  end

  // R4
  // order_chk
  order_chk: assert property (@(posedge clk) disable iff (!rst_n) al_v |-> al_big >= al_small);

  // stage B: add or subtract
  logic          sb_v, sb_sgn;
  logic [EW-1:0] sb_exp;
  logic [MW:0]   sb_sum;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb_v <= 1'b0; sb_sgn <= 1'b0; sb_exp <= '0; sb_sum <= '0;
    end else begin
      sb_v <= al_v;
      if (al_v) begin
        sb_sgn <= al_sgn;
        sb_exp <= al_exp;
        sb_sum <= al_sub ? al_big - al_small : al_big + al_small;
      end
    end
  end

  // stage C: normalize (combinational into the serializer)
  assign res_v = sb_v;
  assign res   = normalize(sb_sum, sb_exp, sb_sgn);

  // R8
  // norm_lead_chk
  norm_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_v && res.sig != '0) |-> res.sig[MW-1]);
  // R9
  // zero_form_chk
  zero_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_v && res.sig == '0) |-> (res.exp == '0 && !res.sgn));
endmodule

// File: rtl/fsa_tx.sv
module fsa_tx
  import fsa_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ld,
  input  fsa_word_t w,
  output logic      sig_bit,
  output logic      se_bit,
  output logic      vld
);
  logic [MW-1:0]  sig_sr;
  logic [SEW-1:0] se_sr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_sr <= '0; se_sr <= '0; vld <= 1'b0;
    end else begin
      vld <= ld;
      if (ld) begin
        sig_sr <= w.sig;
        se_sr  <= {w.sgn, w.exp};
      end else begin
        sig_sr <= {1'b0, sig_sr[MW-1:1]};
        se_sr  <= {1'b0, se_sr[SEW-1:1]};
      end
    end
  end
  assign sig_bit = sig_sr[0];
  assign se_bit  = se_sr[0];

  // R2
  // one_pulse_chk
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) vld |=> !vld);
endmodule

// File: rtl/fsa_serial_add.sv
module fsa_serial_add
  import fsa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_start,
  input  logic a_sig,
  input  logic a_se,
  input  logic b_sig,
  input  logic b_se,
  output logic out_sig,
  output logic out_se,
  output logic out_valid
);
  localparam int CW  = $clog2(MW + 1);
  localparam int LAT = MW + 3;   // start sample to output-valid, in cycles

  // R1: bit counter for the incoming frame
  logic [CW-1:0] cnt;
  logic          busy, sh_sig, sh_se, rx_done;
  assign busy   = (cnt != '0) && (cnt < CW'(MW));
  assign sh_sig = in_start || busy;
  assign sh_se  = in_start || (busy && cnt < CW'(SEW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; rx_done <= 1'b0;
    end else begin
      rx_done <= (cnt == CW'(MW - 1)) && !in_start;
      if (in_start)  cnt <= CW'(1);
      else if (busy) cnt <= cnt + 1'b1;
    end
  end

  logic [1:0]     sig_in, se_in;
  logic [MW-1:0]  op_sig [2];
  logic [SEW-1:0] op_se  [2];
  assign sig_in = {b_sig, a_sig};
  assign se_in  = {b_se, a_se};

  for (genvar g = 0; g < 2; g++) begin : g_op
    fsa_rx #(.W(MW))  u_sig (.clk(clk), .rst_n(rst_n), .shift(sh_sig), .din(sig_in[g]), .q(op_sig[g]));
    fsa_rx #(.W(SEW)) u_se  (.clk(clk), .rst_n(rst_n), .shift(sh_se),  .din(se_in[g]),  .q(op_se[g]));
  end

  logic      res_v;
  fsa_word_t res;
  fsa_core u_core (
    .clk(clk), .rst_n(rst_n), .ld(rx_done),
    .a_sig(op_sig[0]), .a_se(op_se[0]), .b_sig(op_sig[1]), .b_se(op_se[1]),
    .res_v(res_v), .res(res)
  );

  fsa_tx u_tx (
    .clk(clk), .rst_n(rst_n), .ld(res_v), .w(res),
    .sig_bit(out_sig), .se_bit(out_se), .vld(out_valid)
  );

  // R2
  // latency_chk
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_start, LAT));
endmodule

// File: tb/tb_fsa_serial_add.sv
module tb_fsa_serial_add;
  logic clk = 1'b0, rst_n = 1'b0, in_start = 1'b0;
  logic a_sig = 1'b0, a_se = 1'b0, b_sig = 1'b0, b_se = 1'b0;
  logic out_sig, out_se, out_valid;

  fsa_serial_add dut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int nsent = 0, nrecv = 0, cap_n = 0;
  int sent_cyc [64];
  int res_cyc  [64];
  logic [16:0] res_w [64];
  logic [10:0] cur_sig;
  logic [5:0]  cur_se;
  int cur_cyc;

  always @(posedge clk) cyc <= cyc + 1;

  // collector: result bits LSB first, framed by out_valid
  always @(negedge clk) begin
    if (out_valid) begin
      cur_sig = '0; cur_se = '0;
      cur_sig[0] = out_sig; cur_se[0] = out_se;
      cur_cyc = cyc; cap_n = 1;
    end else if (cap_n > 0) begin
      cur_sig[cap_n] = out_sig;
      if (cap_n < 6) cur_se[cap_n] = out_se;
      cap_n++;
      if (cap_n == 11) begin
        res_w[nrecv]   = {cur_se[5], cur_se[4:0], cur_sig};
        res_cyc[nrecv] = cur_cyc;
        nrecv++;
        cap_n = 0;
      end
    end
  end

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent model: {sign, exp[4:0], sig[10:0]}
  function automatic logic [16:0] model(bit sa, int ea, int ma, bit sb, int eb, int mb);
    int bigE, smE, d, lz;
    longint bigM, smM, kept, rem, half, sum;
    bit bigS;
    if (ea > eb || (ea == eb && ma >= mb)) begin
      bigE = ea; bigM = ma; bigS = sa; smE = eb; smM = mb;
    end else begin
      bigE = eb; bigM = mb; bigS = sb; smE = ea; smM = ma;
    end
    d = bigE - smE;
    kept = smM >> d;
    rem  = smM - (kept << d);
    if (d > 0) begin
      half = longint'(1) << (d - 1);
      if (rem > half || (rem == half && kept % 2 == 1)) kept++;
    end
    sum = (sa != sb) ? bigM - kept : bigM + kept;
    if (sum == 0) return '0;
    if (sum >= 2048) begin
      sum = sum / 2;
      return {bigS, 5'((bigE + 1) % 32), 11'(sum)};
    end
    lz = 0;
    while (sum < 1024) begin sum = sum * 2; lz++; end
    if (lz >= bigE) return '0;
    return {bigS, 5'(bigE - lz), 11'(sum)};
  endfunction

  task automatic send(bit sa, int ea, int ma, bit sb, int eb, int mb);
    logic [10:0] am = 11'(ma), bm = 11'(mb);
    logic [5:0]  ase = {sa, 5'(ea)}, bse = {sb, 5'(eb)};
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i == 0) sent_cyc[nsent] = cyc;
      in_start = (i == 0);
      a_sig = (i < 11) ? am[i] : 1'b0;
      b_sig = (i < 11) ? bm[i] : 1'b0;
      a_se  = (i < 6) ? ase[i] : 1'b0;
      b_se  = (i < 6) ? bse[i] : 1'b0;
    end
    nsent++;
  endtask

  // one pair, checks value and latency (R1, R2)
  task automatic run_one(string req, bit sa, int ea, int ma, bit sb, int eb, int mb);
    int k = nsent;
    send(sa, ea, ma, sb, eb, mb);
    wait (nrecv > k);
    check(req, res_w[k], model(sa, ea, ma, sb, eb, mb));
    check("R2 latency", res_cyc[k] - sent_cyc[k], 14);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11 valid", out_valid, 0);
    check("R11 sig", out_sig, 0);
    check("R11 se", out_se, 0);
  endtask

  task automatic t_carry();      // R7: 1.0 + 1.0
    run_one("R7 carry", 0, 15, 1024, 0, 15, 1024);
    check("R7 value", res_w[nsent-1], {1'b0, 5'd16, 11'd1024});
  endtask

  task automatic t_round();      // R5: sticky, tie even, tie odd, shift 11
    run_one("R5 sticky up", 0, 15, 1024, 0, 13, 1027);
    check("R5 sticky value", res_w[nsent-1], {1'b0, 5'd15, 11'd1281});
    run_one("R5 tie even", 0, 15, 1024, 0, 13, 1026);
    check("R5 tie even value", res_w[nsent-1], {1'b0, 5'd15, 11'd1280});
    run_one("R5 tie odd", 0, 15, 1024, 0, 13, 1030);
    check("R5 tie odd value", res_w[nsent-1], {1'b0, 5'd15, 11'd1282});
    run_one("R5 shift11", 0, 20, 1024, 0, 9, 1536);
    check("R5 shift11 value", res_w[nsent-1], {1'b0, 5'd20, 11'd1025});
  endtask

  task automatic t_order();      // R4, R6: B larger, equal exponents
    run_one("R6 sign of larger", 0, 15, 1024, 1, 15, 1536);
    check("R6 value", res_w[nsent-1], {1'b1, 5'd14, 11'd1024});
    run_one("R4 far shift", 1, 1, 2047, 0, 20, 1024);
    check("R4 value", res_w[nsent-1], {1'b0, 5'd20, 11'd1024});
  endtask

  task automatic t_cancel();     // R8, R9, R10
    run_one("R8 left shift", 0, 15, 1030, 1, 15, 1024);
    check("R8 value", res_w[nsent-1], {1'b0, 5'd7, 11'd1536});
    run_one("R9 exact zero", 1, 10, 1500, 0, 10, 1500);
    check("R9 value", res_w[nsent-1], 17'd0);
    run_one("R10 underflow", 0, 2, 1030, 1, 2, 1024);
    check("R10 value", res_w[nsent-1], 17'd0);
  endtask

  task automatic t_stream();     // R3: back-to-back every 12 cycles
    int k = nsent;
    send(0, 17, 1500, 0, 14, 1111);
    send(1, 12, 1800, 0, 12, 1200);
    send(0, 3, 1025, 0, 30, 2047);
    wait (nrecv >= k + 3);
    check("R3 frame0", res_w[k],   model(0, 17, 1500, 0, 14, 1111));
    check("R3 frame1", res_w[k+1], model(1, 12, 1800, 0, 12, 1200));
    check("R3 frame2", res_w[k+2], model(0, 3, 1025, 0, 30, 2047));
    check("R3 spacing", res_cyc[k+2] - res_cyc[k+1], 12);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_carry();
    t_round();
    t_order();
    t_cancel();
    t_stream();
    repeat (20) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule